// File: doc/BRIEF.md
# Serial Command Front End with Self-Timed Array Erase

This block sits between a four-wire serial slave interface and a small on-chip byte-wide memory. The host frames each instruction by pulling the chip select low, clocks the instruction byte (and, for one instruction, a data byte) in on the serial data input, and releases the chip select. The block decodes the frame when the chip select returns high. It keeps a write-enable latch and two protection bits, and it can report them through a status byte. On request it erases the whole array.

The erase is guarded. It starts only when the write-enable latch was set by an earlier frame, when the erase frame held exactly eight bits, and when both protection bits are clear. Once started it runs on the system clock without further serial clocks and writes FFh to one address per cycle. A busy flag in the status byte stays high until the last address has been written. All serial inputs are synchronized into the system clock domain. The serial output has a separate enable so that a pad outside the block can tri-state it.

Top module: `spi_erase_ctrl`

## Requirements
- R1: A completed erase leaves every byte of the array at FFh.
- R2: Instruction 06h (bits sent MSB first, sampled on the rising serial clock, mode 0) sets the write-enable latch only when chip select rises after exactly 8 bits. A frame of any other length does not set it.
- R3: Instruction C7h starts an erase only when three conditions hold: the write-enable latch is 1, chip select rises after exactly 8 bits, and both protection bits are 0. In every other case the array is left untouched.
- R4: While an erase runs, the busy bit reads 1. The erase needs no serial clocks. When the last address is written, the busy bit returns to 0 and the write-enable latch clears.
- R5: Instruction C7h sent with either protection bit set is ignored. It leaves the array untouched and clears the write-enable latch.
- R6: Instruction 01h followed by one data byte (exactly 16 bits in the frame) loads data bit 2 into protection bit 0 and data bit 3 into protection bit 1, and clears the write-enable latch. It does this only when the latch is 1. Otherwise it has no effect.
- R7: Instruction 05h returns the status byte on the serial output, MSB first, updated after each falling serial clock. The layout is bit0 busy, bit1 write-enable latch, bit2 protection bit 0, bit3 protection bit 1, and bits 7..4 read 0.
- R8: The serial output enable is 0 while the instruction byte is shifted in and while chip select is high. It is 1 during the status bits of a 05h frame.
- R9: While the busy bit is 1, every frame other than 05h is dropped, and the latch and protection bits are unchanged.
- R10: After reset the status byte reads 00h, the output enable is 0, and every array byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the external tri-state pad of `so` |
| rd_addr | input | ADDR_W | Array read address for the on-chip consumer |
| rd_data | output | DATA_W | Array read data (combinational) |

## Verification
The bench builds the block with ADDR_W=10, so one erase lasts 1024 system cycles. That window is longer than two full 16-bit serial frames at the bench's serial rate. A status poll can therefore observe the busy bit high mid-erase, and a protection-bit write can be issued and shown to be dropped while the erase is still running. The array is small enough that every address is swept after reset, after each rejected erase and after the completed erase.

// File: rtl/spi_erase_pkg.sv
// Package: instruction codes, status layout and frame classification shared
// by the serial erase controller. Assumes byte-wide instructions, MSB first.
package spi_erase_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_CERASE = 8'hC7;

    // Packed so that the LSB is the busy flag (status bit0).
    typedef struct packed {
        logic bp1;
        logic bp0;
        logic wel;
        logic wip;
    } status_t;

    typedef enum logic [1:0] {
        FR_NONE,
        FR_WREN,
        FR_WRSR,
        FR_CERASE
    } frame_kind_t;

    function automatic logic [7:0] status_byte(input status_t s);
        return {4'b0000, s};
    endfunction

endpackage

// File: rtl/spi_sync.sv
// Module: multi-bit, multi-stage synchronizer for the asynchronous serial pins.
// Assumes each bit is independent and changes slowly relative to clk.
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_sync
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain;

    // Shift the raw pins through STAGES flops per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[CHAIN_W-WIDTH-1:0], d_in};
    end

    assign d_sync = chain[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/spi_cmd_shift.sv
// Module: serial shift engine. It counts the bits in a frame, captures the
// instruction byte and the last data byte, and serialises the status byte for
// a read-status frame. Assumes mode 0 edge pulses that are already synchronized.
module spi_cmd_shift
    import spi_erase_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_low,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             si_bit,
    input  logic [7:0]       status_in,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [7:0]       opcode,
    output logic [7:0]       data_byte,
    output logic             so,
    output logic             so_oe
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_OP  = CNT_W'(7);
    localparam logic [CNT_W-1:0] CNT_TX  = CNT_W'(9);

    logic [7:0] in_sr;
    logic [7:0] out_sr;
    logic       rd_active;
    logic [7:0] next_in;

    assign next_in = {in_sr[6:0], si_bit};

    // Count frame bits and capture the incoming bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            in_sr   <= '0;
            opcode  <= '0;
        end else if (!cs_low) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            in_sr <= next_in;
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_OP)  opcode  <= next_in;
        end
    end

    // Load the status byte after a read-status opcode and shift it out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            out_sr    <= '0;
        end else if (!cs_low) begin
            rd_active <= 1'b0;
        end else if (sck_rise && bit_cnt == CNT_OP && next_in == OP_RDSR) begin
            rd_active <= 1'b1;
            out_sr    <= status_in;
        end else if (sck_fall && rd_active && bit_cnt >= CNT_TX) begin
            out_sr <= {out_sr[6:0], 1'b0};
        end
    end

    assign data_byte = in_sr;
    assign so        = out_sr[7];
    assign so_oe     = rd_active;

endmodule

// File: rtl/spi_status_regs.sv
// Module: frame decoder plus the write-enable latch and protection bits.
// Acts only on the cycle in which chip select rises. It assumes that bit_cnt,
// opcode and data_byte still hold that frame's values in that cycle.
module spi_status_regs
    import spi_erase_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic [7:0]       opcode,
    input  logic [7:0]       data_byte,
    input  logic             wip,
    input  logic             erase_done,
    output logic             wel,
    output logic [1:0]       bp,
    output logic             erase_go
);
    localparam logic [CNT_W-1:0] LEN_CMD  = CNT_W'(8);
    localparam logic [CNT_W-1:0] LEN_DATA = CNT_W'(16);

    frame_kind_t kind;

    // Classify a completed frame by opcode and exact length; drop all while busy.
    always_comb begin
        kind = FR_NONE;
        if (frame_end && !wip) begin
            if      (opcode == OP_WREN   && bit_cnt == LEN_CMD)  kind = FR_WREN;
            else if (opcode == OP_WRSR   && bit_cnt == LEN_DATA) kind = FR_WRSR;
            else if (opcode == OP_CERASE && bit_cnt == LEN_CMD)  kind = FR_CERASE;
        end
    end

    assign erase_go = (kind == FR_CERASE) && wel && (bp == 2'b00);

    // Update the latch and protection bits from the decoded frame or an erase completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
            bp  <= 2'b00;
        end else if (erase_done) begin
            wel <= 1'b0;
        end else begin
            unique case (kind)
                FR_WREN: wel <= 1'b1;
                FR_WRSR: if (wel) begin
                    bp  <= data_byte[3:2];
                    wel <= 1'b0;
                end
                FR_CERASE: if (bp != 2'b00) wel <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spi_erase_engine.sv
// Module: self-timed erase sequencer and the byte array it owns. It writes the
// all-ones word to one address per clock, from 0 to the last address. A
// combinational read port serves the on-chip consumer.
module spi_erase_engine #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_go,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wip,
    output logic              erase_done,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int                DEPTH     = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] mem [DEPTH];

    // Step the erase pointer while busy, and stop after the last address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip <= 1'b0;
            ptr <= '0;
        end else if (erase_go) begin
            wip <= 1'b1;
            ptr <= '0;
        end else if (wip) begin
            if (ptr == LAST_ADDR) wip <= 1'b0;
            else                  ptr <= ptr + 1'b1;
        end
    end

    assign mem_we     = wip;
    assign mem_wdata  = '1;
    assign erase_done = wip && (ptr == LAST_ADDR);

    // Array storage: cleared by reset, written by the erase sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (mem_we) begin
            mem[ptr] <= mem_wdata;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_erase_ctrl.sv
// Module: top of the serial erase controller. It synchronizes the serial pins,
// forms the edge pulses, and connects the shift engine, the status registers
// and the erase sequencer. Assumes the serial clock period is at least eight
// system clocks.
module spi_erase_ctrl
    import spi_erase_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [2:0]       pins_s;
    logic             cs_s, sck_s, si_s;
    logic             cs_p, sck_p;
    logic             sck_rise, sck_fall, cs_rise, cs_low;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       opcode, data_byte;
    logic             wel, wip, erase_go, erase_done;
    logic [1:0]       bp;
    logic             mem_we;
    logic [DATA_W-1:0] mem_wdata;
    status_t          stat;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({cs_n, sck, si}),
        .d_sync(pins_s)
    );

    assign {cs_s, sck_s, si_s} = pins_s;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p  <= 1'b1;
            sck_p <= 1'b0;
        end else begin
            cs_p  <= cs_s;
            sck_p <= sck_s;
        end
    end

    assign sck_rise = sck_s & ~sck_p;
    assign sck_fall = ~sck_s & sck_p;
    assign cs_rise  = cs_s & ~cs_p;
    assign cs_low   = ~cs_s;

    assign stat = '{bp1: bp[1], bp0: bp[0], wel: wel, wip: wip};

    spi_cmd_shift #(.CNT_W(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_low   (cs_low),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_bit   (si_s),
        .status_in(status_byte(stat)),
        .bit_cnt  (bit_cnt),
        .opcode   (opcode),
        .data_byte(data_byte),
        .so       (so),
        .so_oe    (so_oe)
    );

    spi_status_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (cs_rise),
        .bit_cnt   (bit_cnt),
        .opcode    (opcode),
        .data_byte (data_byte),
        .wip       (wip),
        .erase_done(erase_done),
        .wel       (wel),
        .bp        (bp),
        .erase_go  (erase_go)
    );

    spi_erase_engine #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_go  (erase_go),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wip       (wip),
        .erase_done(erase_done),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/spi_erase_ctrl_chk.sv
// Module: assertion checker for the serial erase controller, bound to the top.
module spi_erase_ctrl_chk #(
    parameter int CNT_W  = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wip,
    input logic              wel,
    input logic [1:0]        bp,
    input logic              so_oe,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);
    AST_ERASE_WRITES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == '1)); // R1

    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel)); // R3

    AST_START_NEEDS_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> (bp == 2'b00)); // R3

    AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel); // R4

    AST_OE_AFTER_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (bit_cnt >= CNT_W'(8))); // R8

    AST_PROT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wip |=> $stable(bp)); // R9

endmodule

bind spi_erase_ctrl spi_erase_ctrl_chk #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wip      (wip),
    .wel      (wel),
    .bp       (bp),
    .so_oe    (so_oe),
    .bit_cnt  (bit_cnt),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata)
);

// File: tb/spi_erase_ctrl_tb.sv
// Bench: a vector table of frames and expected status bytes, followed by
// directed tests for reset, rejected erases and a full erase.
module spi_erase_ctrl_tb;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF   = 6;
    localparam int NVEC   = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              sck = 1'b0;
    logic              si = 1'b0;
    logic              so, so_oe;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    spi_erase_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Entry: {req tag, frame bit count, frame bits left-aligned, expected status after}
    localparam logic [32:0] VEC [NVEC] = '{
        {4'd2,  5'd7,  16'h0600, 8'h00},  // R2 short write-enable
        {4'd2,  5'd9,  16'h0600, 8'h00},  // R2 long write-enable
        {4'd2,  5'd8,  16'h0600, 8'h02},  // R2 proper write-enable
        {4'd6,  5'd16, 16'h0104, 8'h04},  // R6 set BP0, clears latch
        {4'd3,  5'd8,  16'hC700, 8'h04},  // R3 erase without latch
        {4'd2,  5'd8,  16'h0600, 8'h06},  // R2
        {4'd5,  5'd8,  16'hC700, 8'h04},  // R5 protected erase clears latch
        {4'd2,  5'd8,  16'h0600, 8'h06},  // R2
        {4'd6,  5'd16, 16'h0108, 8'h08},  // R6 BP1 only
        {4'd6,  5'd16, 16'h0100, 8'h08},  // R6 no latch: ignored
        {4'd2,  5'd8,  16'h0600, 8'h0A},  // R2
        {4'd6,  5'd16, 16'h0100, 8'h00},  // R6 clear protection
        {4'd3,  5'd8,  16'hC700, 8'h00},  // R3 no latch
        {4'd2,  5'd8,  16'h0600, 8'h02},  // R2
        {4'd3,  5'd7,  16'hC600, 8'h02},  // R3 7-bit erase frame
        {4'd3,  5'd9,  16'hC700, 8'h02},  // R3 9-bit erase frame
        {4'd6,  5'd15, 16'h0104, 8'h02}   // R6 wrong-length write-status
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One framed transfer; returns the byte seen on SO during bits 8..15 and OE observations.
    task automatic xfer(input int nbits, input logic [15:0] bits,
                        output logic [7:0] rx, output logic oe_op, output logic oe_data);
        rx = '0; oe_op = 1'b0; oe_data = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            si = (i < 16) ? bits[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 8) oe_op = oe_op | so_oe;
            else if (i < 16) begin
                oe_data = oe_data & so_oe;
                rx = {rx[6:0], so};
            end
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF + 4) @(negedge clk);
    endtask

    task automatic read_status(output logic [7:0] st);
        logic oe_op, oe_data;
        xfer(16, 16'h0500, st, oe_op, oe_data);
        check("R8 oe during opcode", {31'd0, oe_op}, 32'd0);
        check("R8 oe during status bits", {31'd0, oe_data}, 32'd1);
    endtask

    task automatic sweep(input string tag, input logic [7:0] exp);
        int bad = 0;
        logic [7:0] first_bad = exp;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); rd_addr = ADDR_W'(a);
            #1;
            if (rd_data !== exp) begin
                if (bad == 0) first_bad = rd_data;
                bad++;
            end
        end
        check(tag, {24'd0, first_bad}, {24'd0, exp});
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, rx;
        logic oe_op, oe_data;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        check("R10 oe after reset", {31'd0, so_oe}, 32'd0);
        read_status(st);
        check("R10 status after reset", {24'd0, st}, 32'h00);
        sweep("R10 array after reset", 8'h00);

        // Table walk: R2 R3 R5 R6 via status readback (R7 layout)
        for (int v = 0; v < NVEC; v++) begin
            logic [32:0] e;
            e = VEC[v];
            xfer(int'(e[28:24]), e[23:8], rx, oe_op, oe_data);
            read_status(st);
            checks++;
            if (st !== e[7:0]) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual=%0h expected=%0h", e[32:29], v, st, e[7:0]);
            end
        end
        sweep("R3 R5 array untouched by rejected erases", 8'h00);

        // R4 R9: start a valid erase (latch already 1, protection 0)
        xfer(8, 16'hC700, rx, oe_op, oe_data);
        read_status(st);
        check("R4 busy and latch mid-erase", {24'd0, st}, 32'h03);
        xfer(16, 16'h010C, rx, oe_op, oe_data);   // R9: dropped while busy
        check("R8 oe low with cs high", {31'd0, so_oe}, 32'd0);
        repeat (1200) @(negedge clk);
        read_status(st);
        check("R4 R9 status after erase", {24'd0, st}, 32'h00);
        sweep("R1 array all ones", 8'hFF);

        // R9 follow-up: a write-status now needs the latch, so it stays ignored
        xfer(16, 16'h010C, rx, oe_op, oe_data);
        read_status(st);
        check("R6 no latch after erase", {24'd0, st}, 32'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule